// File: doc/BRIEF.md
# Sense-Reversing Barrier Unit

The unit lets a fixed group of hardware participants meet at a common point before any of them continues. A participant signals that it has reached the barrier with a one-cycle arrive pulse, then holds until its go output is high again. The unit tracks how many participants have arrived in the current episode and keeps one global release flag. Every participant owns a local sense bit, which is inverted when its arrival is accepted and is visible as an output.

A participant is free to proceed whenever its local sense equals the release flag. When the arrivals of an episode reach the participant count, the counter returns to zero and the release flag takes the sense value of that episode's arrivers, which lets every waiter go in the same cycle. Because each episode uses the opposite sense value from the one before it, the barrier can be reused back to back. A participant that has just left cannot be mistaken for one that has already arrived at the next episode, and no flag has to be cleared when a new episode begins, so the deadlock of a clear-on-first-arrival scheme cannot occur. Arrivals that land in the same cycle are all counted. An arrive pulse from a participant that is still waiting has no effect and raises a protocol error pulse.

Top module: `sense_barrier`

## Requirements
- R1: After reset every sense bit is 0, the release flag is 0, the arrival count is 0, every go bit is 1 and proto_err is 0.
- R2: An arrive on bit i while go[i] is 1 is accepted, and sense[i] is inverted at the next clock edge.
- R3: go[i] is 1 exactly when sense[i] equals the release flag; after an accepted arrival that does not complete the episode, go[i] is 0 from the next cycle until the episode completes.
- R4: Every accepted arrival in one cycle adds one to the count, including several in the same cycle, so an episode needs exactly N_PART accepted arrivals.
- R5: In the cycle after the accepted arrivals reach N_PART, every go bit is 1, the release flag equals the arrivers' new sense value and the count is 0.
- R6: The participant whose arrival completes an episode sees go stay 1 without a low cycle.
- R7: A participant may arrive again in the cycle right after its release; that arrival belongs to the next episode and does not complete it early.
- R8: An arrive on bit i while go[i] is 0 changes neither sense[i] nor the count, and makes proto_err 1 for exactly the next cycle; proto_err is 0 in any cycle after a cycle with no such arrive.
- R9: Reset in the middle of an episode discards its partial count, so the next episode needs N_PART fresh arrivals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive | input | N_PART | One-cycle arrival pulse per participant |
| go | output | N_PART | High when the participant may proceed |
| sense | output | N_PART | Local sense bit of each participant |
| proto_err | output | 1 | Pulse one cycle after an arrive from a waiting participant |

## Verification
The checker watches every cycle that accepted arrivals flip their sense bit, that ignored arrivals leave it alone and raise the error pulse, that a non-final arrival drops go, and that completion raises every go bit and clears the count. What only the bench's scenarios show is the episode arithmetic over time: that coincident arrivals add up, that a mix of accepted and rejected arrivals in one cycle can still complete an episode, that an immediate re-arrival starts a fresh episode instead of leaking into the old one, and that a reset mid-episode throws away the partial count.

// File: rtl/sb_pkg.sv
// Package: shared helpers for the sense-reversing barrier.
// Assumes no barrier has more than 64 participants.
package sb_pkg;
    localparam int unsigned SB_MAX_PART = 64;

    // Count the set bits of a vector of up to SB_MAX_PART bits.
    function automatic int unsigned sb_ones(input logic [SB_MAX_PART-1:0] v);
        int unsigned n;
        n = 0;
        for (int k = 0; k < SB_MAX_PART; k++) begin
            n = n + int'(v[k]);
        end
        return n;
    endfunction
endpackage

// File: rtl/sb_participant.sv
// Module: one participant's slot. Holds the local sense bit, flips it when an
// arrival is accepted, and derives go from a compare with the release flag.
// Assumes release_flag is the registered global flag.
module sb_participant (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic release_flag,
    output logic accept,
    output logic ignored,
    output logic sense,
    output logic go
);
    logic sense_q;

    // Free to proceed while the local sense matches the release flag.
    always_comb begin
        go      = (sense_q == release_flag);
        accept  = arrive & go;
        ignored = arrive & ~go;
        sense   = sense_q;
    end

    // Invert the local sense on each accepted arrival.
    always_ff @(posedge clk) begin
        if (!rst_n)      sense_q <= 1'b0;
        else if (accept) sense_q <= ~sense_q;
    end
endmodule

// File: rtl/sb_counter.sv
// Module: shared arrival counter and release flag. Adds all accepted
// arrivals of a cycle; when the total reaches N_PART it clears the count and
// flips the release flag to the arrivers' new sense.
// Assumes a participant is accepted at most once per episode.
module sb_counter #(
    parameter int unsigned N_PART = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] accept,
    output logic              complete,
    output logic              release_flag,
    output logic [$clog2(N_PART+1)-1:0] count
);
    import sb_pkg::*;
    localparam int unsigned CW = $clog2(N_PART + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] n_new;
    logic [CW-1:0] total;
    logic          rel_q;
    logic [SB_MAX_PART-1:0] acc_wide;

    // Sum this cycle's accepted arrivals with the running count.
    always_comb begin
        acc_wide = '0;
        acc_wide[N_PART-1:0] = accept;
        n_new    = CW'(sb_ones(acc_wide));
        total    = cnt_q + n_new;
        complete = (total == CW'(N_PART));
        release_flag = rel_q;
        count    = cnt_q;
    end

    // Advance the count, or clear it and reverse the release flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rel_q <= 1'b0;
        end else if (complete) begin
            cnt_q <= '0;
            rel_q <= ~rel_q;
        end else begin
            cnt_q <= total;
        end
    end
endmodule

// File: rtl/sb_err_flag.sv
// Module: protocol error pulse. High for one cycle after any cycle in which
// a waiting participant pulsed arrive.
module sb_err_flag #(
    parameter int unsigned N_PART = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] ignored,
    output logic              proto_err
);
    // Register whether any arrival was rejected this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= |ignored;
    end
endmodule

// File: rtl/sense_barrier.sv
// Module: sense-reversing barrier for N_PART participants. One slot per
// participant, a shared counter/flag, and an error pulse.
// Assumes arrive pulses are synchronous to clk and N_PART <= 64.
module sense_barrier #(
    parameter int unsigned N_PART = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PART-1:0] arrive,
    output logic [N_PART-1:0] go,
    output logic [N_PART-1:0] sense,
    output logic              proto_err
);
    localparam int unsigned CW = $clog2(N_PART + 1);

    logic [N_PART-1:0] accept_w;
    logic [N_PART-1:0] ignored_w;
    logic              release_w;
    logic              complete_w;
    logic [CW-1:0]     cnt_w;

    // One slot per participant.
    for (genvar i = 0; i < N_PART; i++) begin : g_slot
        sb_participant u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .arrive       (arrive[i]),
            .release_flag (release_w),
            .accept       (accept_w[i]),
            .ignored      (ignored_w[i]),
            .sense        (sense[i]),
            .go           (go[i])
        );
    end

    sb_counter #(.N_PART(N_PART)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept_w),
        .complete     (complete_w),
        .release_flag (release_w),
        .count        (cnt_w)
    );

    sb_err_flag #(.N_PART(N_PART)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .ignored   (ignored_w),
        .proto_err (proto_err)
    );
endmodule

// File: rtl/sb_barrier_chk.sv
// Module: property checker for sense_barrier, attached with bind.
module sb_barrier_chk #(
    parameter int unsigned N_PART = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PART-1:0] arrive,
    input logic [N_PART-1:0] go,
    input logic [N_PART-1:0] sense,
    input logic              proto_err,
    input logic              complete,
    input logic              release_flag,
    input logic [$clog2(N_PART+1)-1:0] count
);
    AST_ERR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(arrive & ~go)) |=> proto_err); // R8
    AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(arrive & ~go)) |=> !proto_err); // R8
    AST_ALL_GO_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (&go)); // R5
    AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (count == '0)); // R5
    AST_REL_TRACKS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (release_flag == sense[0])); // R5

    for (genvar i = 0; i < N_PART; i++) begin : g_bit
        AST_SENSE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
            (arrive[i] && go[i]) |=> (sense[i] != $past(sense[i]))); // R2
        AST_SENSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !(arrive[i] && go[i]) |=> $stable(sense[i])); // R8
        AST_WAITER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (arrive[i] && go[i] && !complete) |=> !go[i]); // R3
        AST_LAST_STAYS_GO: assert property (@(posedge clk) disable iff (!rst_n)
            (arrive[i] && go[i] && complete) |=> go[i]); // R6
    end
endmodule

bind sense_barrier sb_barrier_chk #(.N_PART(N_PART)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arrive       (arrive),
    .go           (go),
    .sense        (sense),
    .proto_err    (proto_err),
    .complete     (complete_w),
    .release_flag (release_w),
    .count        (cnt_w)
);

// File: tb/tb_sense_barrier.sv
module tb_sense_barrier;
    localparam int N = 4;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] go;
    logic [N-1:0] sense;
    logic         proto_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    sense_barrier #(.N_PART(N)) dut (
        .clk(clk), .rst_n(rst_n), .arrive(arrive),
        .go(go), .sense(sense), .proto_err(proto_err)
    );

    // {arrive, expected sense, expected go, expected err}
    localparam logic [12:0] VEC [0:NV-1] = '{
        {4'b0001, 4'b0001, 4'b1110, 1'b0}, // R2 R3 first arrival
        {4'b0001, 4'b0001, 4'b1110, 1'b1}, // R8 repeat while waiting
        {4'b0110, 4'b0111, 4'b1000, 1'b0}, // R4 two at once, err pulse gone
        {4'b0000, 4'b0111, 4'b1000, 1'b0}, // R3 idle, still waiting
        {4'b1000, 4'b1111, 4'b1111, 1'b0}, // R5 R6 last arrival releases all
        {4'b1111, 4'b0000, 4'b1111, 1'b0}, // R4 R5 R7 whole episode in one cycle
        {4'b0011, 4'b0011, 4'b1100, 1'b0}, // R7 back-to-back reuse
        {4'b1111, 4'b1111, 4'b1111, 1'b1}, // R4 R8 two rejected, two complete
        {4'b0001, 4'b1110, 4'b1110, 1'b0}, // R7 immediate re-arrival
        {4'b0100, 4'b1010, 4'b1010, 1'b0}, // R4 second of new episode
        {4'b0001, 4'b1010, 4'b1010, 1'b1}, // R8 ignored, no count
        {4'b1010, 4'b0000, 4'b1111, 1'b0}  // R5 completes with exactly four
    };

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] a);
        arrive = a;
        @(negedge clk);
        arrive = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 sense", sense, 4'b0000);
        chk("R1 go", go, 4'b1111);
        chk("R1 err", {3'b0, proto_err}, 4'b0000);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][12:9]);
            chk($sformatf("R2 sense vec%0d", k), sense, VEC[k][8:5]);
            chk($sformatf("R3 go vec%0d", k), go, VEC[k][4:1]);
            chk($sformatf("R8 err vec%0d", k), {3'b0, proto_err}, {3'b0, VEC[k][0]});
        end

        // R9 reset mid-episode discards the partial count
        step(4'b0011);
        chk("R3 go partial", go, 4'b1100);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 sense after reset", sense, 4'b0000);
        chk("R9 go after reset", go, 4'b1111);
        step(4'b0001);
        step(4'b0010);
        step(4'b0100);
        chk("R9 three of four still wait", go, 4'b1000);
        step(4'b1000);
        chk("R9 fourth releases", go, 4'b1111);
        chk("R6 sense all flipped", sense, 4'b1111);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule